// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C bus master read and write a bank of 8-bit registers. SCL and SDA are oversampled by a fast system clock. Each line passes through a stability filter that discards pulses shorter than a set number of clock cycles. The filtered lines feed an edge and bus-condition detector, which reports START, STOP and the rising and falling SCL edges. A bit and byte state machine then decodes the device address, acknowledges bytes, and moves data through a simple synchronous register-file port.

A write transfer first loads an internal register pointer and then stores each further byte at the pointer, advancing the pointer after every byte. A read transfer returns bytes from wherever the pointer was left, in the same or an earlier transfer. A repeated START restarts address decoding but keeps the pointer, so a master can set the pointer and read from it within one bus tenure. SDA is only ever pulled low or released, through `sda_oe`.

Top module: `i2c_reg_slave`

## Requirements
- R1: `sda_oe` is 1 only to pull SDA low, and 0 otherwise. After reset, `sda_oe`, `reg_we` and `reg_re` are all 0.
- R2: A level on `scl_i` or `sda_i` that lasts fewer than `FILT_CYCLES` system clock cycles has no effect. The default of 14 cycles covers 50 ns at 250 MHz. Such a pulse neither clocks a bit nor forms a START or STOP.
- R3: `sda_oe` changes only while the filtered SCL is low. START and STOP are the only exceptions, and they only ever release SDA.
- R4: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP ends any transfer at once and releases SDA. A partially received byte is discarded and is not written.
- R5: The first byte after a START is the 7-bit device address, MSB first, followed by the direction bit (1 = read). The address is acknowledged only if it equals `DEV_ADDR` (default 7'h3A). On a mismatch SDA stays released, and the block ignores the bus until the next START. No strobe is issued and the pointer is not touched.
- R6: In a write transfer, the byte after the address loads the pointer. Each later byte raises `reg_we` for one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments, wrapping from 8'hFF to 8'h00.
- R7: In a read transfer, each byte is fetched by a one-cycle `reg_re` at the pointer. `reg_rdata` is sampled in the following cycle. The byte is shifted out MSB first, and the pointer then increments.
- R8: The block acknowledges, by pulling SDA low in the ninth clock, every matching address byte, every pointer byte and every write data byte.
- R9: A repeated START without a preceding STOP restarts address decoding and keeps the pointer. A write of a pointer followed by a read therefore returns the register at that pointer.
- R10: When the master does not acknowledge a read byte, the block releases SDA and issues no further `reg_re` until the next START.
- R11: The pointer persists across STOP. A new read transfer starts at the pointer left by the last write or read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases the line |
| reg_addr | output | PTR_W (8) | Register pointer presented to the register file |
| reg_wdata | output | 8 | Data byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |

## Verification
On a read, the rising SCL edge of the master's acknowledge clock both samples the master's ACK or NACK and decides whether the next register is prefetched, advancing the pointer. Both actions fall on that one edge. The bench provokes the collision by ending a three-byte read with a NACK. It then judges the outcome in two ways: the count of read strobes must grow by exactly three, and a later read in a fresh transfer must return the register just past the last byte delivered. A second overlap comes from a write byte's strobe, which sits in the same acknowledge slot as the ACK drive. The scoreboard checks that the strobe and its pointer address line up with the byte the master sent.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } slv_state_e;

  // Device address sits in the upper seven bits; bit 0 is the direction.
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int   STABLE_CYCLES = 14,
  parameter logic RESET_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= {2{RESET_LEVEL}};
      run_q   <= '0;
      level_q <= RESET_LEVEL;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  // R2: the filtered level only ever moves toward what the synchronizer holds
  p_filter_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync_q[1]) == level_q));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  output logic             sda_pull,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata
);
  localparam logic [3:0] ACK_POS = 4'd8;
  localparam logic [3:0] END_POS = 4'd9;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  slv_state_e       state_q;
  logic [3:0]       bit_q;
  logic [7:0]       shift_q, tx_q, wdata_q;
  logic [PTR_W-1:0] ptr_q;
  logic             pull_q, rw_q, mack_q, we_q, re_q, re_d;

  // Named bus events inside a byte slot
  logic active_w, bit_rx_w, ack_sample_w, byte_done_w, slot_end_w;
  assign active_w     = (state_q != ST_IDLE) && (state_q != ST_IGNORE);
  assign bit_rx_w     = active_w && scl_rise && (bit_q < ACK_POS);
  assign ack_sample_w = active_w && scl_rise && (bit_q == ACK_POS);
  assign byte_done_w  = active_w && scl_fall && (bit_q == ACK_POS);
  assign slot_end_w   = active_w && scl_fall && (bit_q == END_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      re_d    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      re_d <= re_q;
      if (re_d) tx_q <= reg_rdata;
      if (we_q || re_q) ptr_q <= ptr_next(ptr_q);

      if (stop_ev) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
        bit_q   <= '0;
      end else if (start_ev) begin
        state_q <= ST_ADDR;
        pull_q  <= 1'b0;
        bit_q   <= '0;
      end else if (active_w) begin
        if (scl_rise) begin
          if (bit_rx_w) shift_q <= {shift_q[6:0], sda_f};
          if (ack_sample_w) begin
            mack_q <= ~sda_f;
            if (state_q == ST_RDATA && !sda_f) re_q <= 1'b1;
          end
          if (bit_q != END_POS) bit_q <= bit_q + 4'd1;
        end
        if (byte_done_w) begin
          unique case (state_q)
            ST_ADDR: begin
              if (addr_hit(shift_q, DEV_ADDR)) begin
                pull_q <= 1'b1;
                rw_q   <= shift_q[0];
                if (shift_q[0]) re_q <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            ST_PTR: begin
              pull_q <= 1'b1;
              ptr_q  <= shift_q[PTR_W-1:0];
            end
            ST_WDATA: begin
              pull_q  <= 1'b1;
              we_q    <= 1'b1;
              wdata_q <= shift_q;
            end
            default: pull_q <= 1'b0;
          endcase
        end else if (slot_end_w) begin
          bit_q <= '0;
          unique case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                pull_q  <= ~tx_q[7];
                tx_q    <= {tx_q[6:0], 1'b0};
              end else begin
                state_q <= ST_PTR;
                pull_q  <= 1'b0;
              end
            end
            ST_PTR: begin
              state_q <= ST_WDATA;
              pull_q  <= 1'b0;
            end
            ST_RDATA: begin
              if (mack_q) begin
                pull_q <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
              end else begin
                state_q <= ST_IGNORE;
                pull_q  <= 1'b0;
              end
            end
            default: pull_q <= 1'b0;
          endcase
        end else if (scl_fall && state_q == ST_RDATA) begin
          pull_q <= ~tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_pull  = pull_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;

  // R3: the drive on SDA moves only while SCL is low, START/STOP releases aside
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull != $past(sda_pull)) && !$past(start_ev || stop_ev)) |-> !scl_f);

  // R6: a write strobe is followed by a one-step pointer advance
  p_we_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == ptr_next($past(reg_addr))));

  // R7: a read strobe is followed by a one-step pointer advance
  p_re_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (reg_addr == ptr_next($past(reg_addr))));

  // R6: the register port never sees both strobes together
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re}));

  // R4: a STOP leaves the line released and the engine idle
  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_pull && state_q == ST_IDLE));

  // R5: an ignored transfer neither drives SDA nor writes
  p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!sda_pull && !reg_we && !reg_re));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         FILT_CYCLES = 14,
  parameter int         PTR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_w, filt_w;
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2cs_glitch_filter #(
      .STABLE_CYCLES(FILT_CYCLES),
      .RESET_LEVEL  (1'b1)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (raw_w[g]),
      .level_o(filt_w[g])
    );
  end

  assign scl_f = filt_w[1];
  assign sda_f = filt_w[0];

  i2cs_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2cs_engine #(
    .DEV_ADDR(DEV_ADDR),
    .PTR_W   (PTR_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_pull (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_rdata(reg_rdata)
  );

  // R1: the output enable is never unknown once out of reset
  p_oe_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(sda_oe));

endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 25;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  logic sda_bus;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  int re_count = 0;
  int r3_viol = 0;
  bit finished = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t exp_wq[$];
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] exp_ptr = 8'h00;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7) + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Register file: read data valid one cycle after the strobe
  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
  end

  // Monitor: pops the write scoreboard and watches the SDA drive timing
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_re) re_count++;
      if (reg_we) begin
        if (exp_wq.size() == 0) begin
          chk(0, "R6 unexpected write", int'(reg_addr), -1);
        end else begin
          wr_t e;
          e = exp_wq.pop_front();
          chk(reg_addr == e.a, "R6 write address", int'(reg_addr), int'(e.a));
          chk(reg_wdata == e.d, "R6 write data", int'(reg_wdata), int'(e.d));
        end
      end
      if (sda_oe != oe_prev && scl_m) r3_viol++;
      oe_prev = sda_oe;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(Q);
    scl_m = 1'b1; w(2 * Q);
    scl_m = 1'b0; w(Q);
  endtask

  // Same bit with a short SCL pulse while low and a short SDA flip while high
  task automatic send_bit_glitchy(input logic b);
    sda_m = b; w(Q);
    scl_m = 1'b1; w(8);
    scl_m = 1'b0; w(Q);
    scl_m = 1'b1; w(8);
    sda_m = ~b; w(8);
    sda_m = b; w(2 * Q - 16);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    b = sda_bus;
    w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack_m);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack_m);
  endtask

  // Driver helpers: push expectations, then drive the bus
  task automatic addr_phase(input logic rd, input string req);
    logic ack;
    send_byte({DEV, rd}, ack);
    chk(ack, req, int'(ack), 1);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic ack;
    send_byte(p, ack);
    chk(ack, "R8 pointer ack", int'(ack), 1);
    exp_ptr = p;
  endtask

  task automatic wr_data(input logic [7:0] d);
    logic ack;
    exp_wq.push_back('{a: exp_ptr, d: d});
    shadow[exp_ptr] = d;
    exp_ptr = exp_ptr + 8'd1;
    send_byte(d, ack);
    chk(ack, "R8 data ack", int'(ack), 1);
  endtask

  task automatic rd_data(input bit last, input string req);
    logic [7:0] v;
    logic [7:0] e;
    e = shadow[exp_ptr];
    exp_ptr = exp_ptr + 8'd1;
    recv_byte(v, !last);
    chk(v == e, req, int'(v), int'(e));
  endtask

  initial begin
    logic ack;
    logic b;
    int re_before;
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    w(10);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    chk(reg_we == 1'b0, "R1 reset reg_we", int'(reg_we), 0);
    chk(reg_re == 1'b0, "R1 reset reg_re", int'(reg_re), 0);
    rst_n = 1'b1;
    w(40);
    chk(sda_oe == 1'b0, "R1 idle sda_oe", int'(sda_oe), 0);

    // R6/R8: plain write of three bytes
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'h10);
    wr_data(8'hA5);
    wr_data(8'h3C);
    wr_data(8'hFF);
    bus_stop();
    w(Q);
    chk(sda_oe == 1'b0, "R4 released after stop", int'(sda_oe), 0);

    // R9/R7/R10: pointer write, repeated START, read three, NACK the last
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'h10);
    bus_rstart();
    re_before = re_count;
    addr_phase(1'b1, "R9 address ack after repeated start");
    rd_data(1'b0, "R9 read first byte at pointer");
    rd_data(1'b0, "R7 read second byte");
    rd_data(1'b1, "R7 read third byte");
    recv_bit(b);
    chk(b == 1'b1, "R10 SDA released after nack", int'(b), 1);
    recv_bit(b);
    chk(b == 1'b1, "R10 SDA still released", int'(b), 1);
    chk(re_count - re_before == 3, "R10 read strobes", re_count - re_before, 3);
    bus_stop();

    // R11: fresh read resumes at pointer
    bus_start();
    addr_phase(1'b1, "R5 address ack read");
    rd_data(1'b1, "R11 read resumes after stop");
    bus_stop();

    // R5: wrong device address is ignored
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    chk(ack == 1'b0, "R5 mismatched address nack", int'(ack), 0);
    send_byte(8'h20, ack);
    chk(ack == 1'b0, "R5 ignored pointer byte", int'(ack), 0);
    send_byte(8'h77, ack);
    chk(ack == 1'b0, "R5 ignored data byte", int'(ack), 0);
    bus_stop();
    bus_start();
    addr_phase(1'b1, "R5 address ack read");
    rd_data(1'b1, "R5 pointer untouched by ignored transfer");
    bus_stop();

    // R4: STOP in mid-byte discards the byte
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'h30);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    bus_start();
    addr_phase(1'b1, "R4 address ack read after abort");
    rd_data(1'b1, "R4 aborted byte not written");
    bus_stop();

    // R6: pointer wraps
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'hFF);
    wr_data(8'h11);
    wr_data(8'h22);
    bus_stop();

    // R2: glitches on both lines during a data byte
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'h40);
    exp_wq.push_back('{a: 8'h40, d: 8'h96});
    shadow[8'h40] = 8'h96;
    exp_ptr = 8'h41;
    for (int i = 7; i >= 0; i--) send_bit_glitchy(8'h96 >> i);
    recv_bit(b);
    chk(b == 1'b0, "R2 byte with glitches acknowledged", int'(b), 0);
    bus_stop();
    bus_start();
    addr_phase(1'b0, "R5 address ack write");
    set_ptr(8'h40);
    bus_rstart();
    addr_phase(1'b1, "R9 address ack read");
    rd_data(1'b1, "R2 glitch-free byte stored");
    bus_stop();

    w(4 * Q);
    chk(exp_wq.size() == 0, "R6 all writes seen", exp_wq.size(), 0);
    chk(r3_viol == 0, "R3 SDA drive changed only with SCL low", r3_viol, 0);
    finish_run();
  end

endmodule